// File: doc/BRIEF.md
# Call-Stub Target Learning Table

This block sits beside the retire stage of an out-of-order core. It learns where small linkage stubs finally send control. A retired call leaves its resolved target in a one-entry latch. If the very next retired instruction is an indirect branch, the block writes a table entry whose key is that call target (the stub address) and whose value is the indirect branch's resolved target (the real function). In the same step it reports the memory address that the indirect branch loaded its pointer from, so that a separate address filter can watch that location for later stores.

Branch resolution queries the table through a combinational lookup port. A hit there lets the core accept a prediction that skipped the stub. The table is fully associative. Its entries are never removed one at a time. Two clear inputs empty the whole table at once: one is driven by a hit in the filter, the other by a context switch.

Top module: `stub_target_table`

## Requirements
- R1: After reset no entry is valid, every lookup misses with lk_target zero, and rec_valid is low.
- R2: A retired call (ret_kind 1) latches its ret_target. If the next retired instruction is an indirect branch (ret_kind 2), an entry is written with key = latched call target and value = that branch's ret_target. The lookup hits on it from the cycle after the branch retires.
- R3: If the instruction retired right after a call is of any other kind (ret_kind 0 or 3), no entry is written.
- R4: Cycles with ret_valid low do not count as retired instructions, so a call and an indirect branch separated only by such cycles still form a pair.
- R5: rec_valid is high for exactly the cycle after an entry is written, with rec_addr equal to the ret_ptr_addr of the indirect branch. It is low in all other cycles.
- R6: Writing a key that is already present replaces the value in that entry. No other entry is lost.
- R7: Empty slots are filled before any valid entry is replaced. Once all slots are valid, victims are chosen round robin, starting at slot 0 after reset or a clear and advancing only on such a replacement.
- R8: clr_filter or clr_ctx high for one cycle invalidates every entry, drops a latched call and restarts the victim order at slot 0. A call retiring in a clear cycle is not latched.
- R9: A clear in the same cycle as a pair-completing indirect branch wins: no entry is written and rec_valid stays low.
- R10: The lookup is combinational. lk_hit and lk_target follow lk_addr within the cycle, a miss returns lk_target zero, and invalid slots never hit.
- R11: An indirect branch retired with no latched call writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_kind | input | 2 | 0 other, 1 call, 2 indirect branch, 3 other |
| ret_target | input | AW | Resolved target of the retiring instruction |
| ret_ptr_addr | input | AW | Address the retiring indirect branch loaded its pointer from |
| clr_filter | input | 1 | Clear request from the address filter |
| clr_ctx | input | 1 | Clear request on context switch |
| lk_addr | input | AW | Lookup key (stub address) |
| lk_hit | output | 1 | A valid entry matches lk_addr |
| lk_target | output | AW | Value of the matching entry, zero on a miss |
| rec_valid | output | 1 | An entry was written in the previous cycle |
| rec_addr | output | AW | Pointer address to be recorded by the filter |

## Verification
The bench builds the table with DEPTH=4 and AW=48. With so few slots, a handful of installs fills the table, so round-robin eviction, pointer wrap and update-in-place on a full table all become reachable. The full-width addresses exercise upper-bit key compares. A long random phase draws call targets from a pool larger than the table, so clears, overwrites and evictions interleave with pending calls. The 256-entry default and the 16-entry configuration are only elaborated.

// File: rtl/stt_pkg.sv
package stt_pkg;
  typedef enum logic [1:0] {
    RK_OTHER = 2'd0,
    RK_CALL  = 2'd1,
    RK_IND   = 2'd2,
    RK_RET   = 2'd3
  } ret_kind_e;
endpackage

// File: rtl/stt_pair_detect.sv
// Watches the retire stream for call -> indirect-branch adjacency.
module stt_pair_detect
  import stt_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_valid,
  input  logic [1:0]    ret_kind,
  input  logic [AW-1:0] ret_target,
  input  logic          clr,
  output logic          inst_req,
  output logic [AW-1:0] inst_key,
  output logic [AW-1:0] inst_val,
  output logic          pend_valid
);
  logic          pend_q, pend_d;
  logic [AW-1:0] key_q, key_d;
  logic          key_en;
  logic          is_call, is_ind;

  always_comb begin
    is_call  = ret_valid && (ret_kind_e'(ret_kind) == RK_CALL);
    is_ind   = ret_valid && (ret_kind_e'(ret_kind) == RK_IND);
    inst_req = is_ind && pend_q && !clr;
    inst_key = key_q;
    inst_val = ret_target;
    pend_d   = pend_q;
    key_en   = 1'b0;
    key_d    = key_q;
    if (clr) begin
      pend_d = 1'b0;
    end else if (ret_valid) begin
      // any retired instruction ends the pairing window; only a call opens it
      pend_d = is_call;
      if (is_call) begin
        key_en = 1'b1;
        key_d  = ret_target;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (key_en) key_q <= key_d;
  end

  assign pend_valid = pend_q;
endmodule

// File: rtl/stt_victim_ptr.sv
// Round-robin replacement pointer, advanced only on a full-table replacement.
module stt_victim_ptr #(
  parameter int DEPTH = 256,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)      ptr_d = '0;
    else if (adv) ptr_d = (ptr_q == IW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/stt_entry_array.sv
// Fully associative storage with one write port and one combinational lookup.
module stt_entry_array #(
  parameter int DEPTH = 256,
  parameter int AW    = 48,
  parameter int IW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_key,
  input  logic [AW-1:0]    wr_val,
  input  logic [IW-1:0]    victim,
  input  logic [AW-1:0]    lk_addr,
  output logic             lk_hit,
  output logic [AW-1:0]    lk_val,
  output logic             adv,
  output logic [DEPTH-1:0] valid_vec
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] wmatch, lmatch, wsel;
  logic [AW-1:0]    masked [DEPTH];
  logic             any_match, any_free;
  logic [IW-1:0]    match_idx, free_idx, wr_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] key_r, val_r;

    always_ff @(posedge clk) begin
      if (wsel[g]) begin
        key_r <= wr_key;
        val_r <= wr_val;
      end
    end

    assign wmatch[g] = vld_q[g] && (key_r == wr_key);
    assign lmatch[g] = vld_q[g] && (key_r == lk_addr);
    assign masked[g] = {AW{lmatch[g]}} & val_r;
  end

  // slot selection: existing key, then lowest free slot, then victim pointer
  always_comb begin
    any_match = |wmatch;
    any_free  = ~&vld_q;
    match_idx = '0;
    free_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (wmatch[i]) match_idx = IW'(i);
      if (!vld_q[i]) free_idx  = IW'(i);
    end
    if (any_match)     wr_idx = match_idx;
    else if (any_free) wr_idx = free_idx;
    else               wr_idx = victim;
    adv  = wr_en && !any_match && !any_free;
    wsel = '0;
    if (wr_en) wsel[wr_idx] = 1'b1;
    vld_d = clr ? '0 : (vld_q | wsel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_comb begin
    lk_hit = |lmatch;
    lk_val = '0;
    for (int i = 0; i < DEPTH; i++) lk_val = lk_val | masked[i];
  end

  assign valid_vec = vld_q;
endmodule

// File: rtl/stub_target_table.sv
module stub_target_table
  import stt_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_valid,
  input  logic [1:0]    ret_kind,
  input  logic [AW-1:0] ret_target,
  input  logic [AW-1:0] ret_ptr_addr,
  input  logic          clr_filter,
  input  logic          clr_ctx,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [AW-1:0] lk_target,
  output logic          rec_valid,
  output logic [AW-1:0] rec_addr
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]       rs_q;
  logic             rst_n_i;
  logic             clr;
  logic             inst_req;
  logic [AW-1:0]    inst_key, inst_val;
  logic             pend_w;
  logic             adv;
  logic [IW-1:0]    victim;
  logic [DEPTH-1:0] valid_w;
  logic             rec_v_q, rec_v_d;
  logic [AW-1:0]    rec_a_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  assign clr = clr_filter | clr_ctx;

  stt_pair_detect #(.AW(AW)) u_pair (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .ret_valid  (ret_valid),
    .ret_kind   (ret_kind),
    .ret_target (ret_target),
    .clr        (clr),
    .inst_req   (inst_req),
    .inst_key   (inst_key),
    .inst_val   (inst_val),
    .pend_valid (pend_w)
  );

  stt_victim_ptr #(.DEPTH(DEPTH)) u_vptr (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (clr),
    .adv   (adv),
    .ptr   (victim)
  );

  stt_entry_array #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .clr       (clr),
    .wr_en     (inst_req),
    .wr_key    (inst_key),
    .wr_val    (inst_val),
    .victim    (victim),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_val    (lk_target),
    .adv       (adv),
    .valid_vec (valid_w)
  );

  // pointer-address hand-off to the filter, one cycle after the install
  assign rec_v_d = inst_req;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rec_v_q <= 1'b0;
    else          rec_v_q <= rec_v_d;
  end

  always_ff @(posedge clk) begin
    if (inst_req) rec_a_q <= ret_ptr_addr;
  end

  assign rec_valid = rec_v_q;
  assign rec_addr  = rec_a_q;
endmodule

// File: rtl/stt_checker.sv
module stt_checker #(
  parameter int DEPTH = 256,
  parameter int AW    = 48
) (
  input logic             clk,
  input logic             rst_n_i,
  input logic             ret_valid,
  input logic [1:0]       ret_kind,
  input logic [AW-1:0]    ret_ptr_addr,
  input logic             clr,
  input logic             pend_w,
  input logic             lk_hit,
  input logic             rec_valid,
  input logic [AW-1:0]    rec_addr,
  input logic [DEPTH-1:0] valid_w
);
  // ret_kind 2 is the indirect branch
  p_rec_from_pair_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    rec_valid |-> $past(ret_valid && ret_kind == 2'd2 && pend_w && !clr));

  p_rec_addr_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    rec_valid |-> rec_addr == $past(ret_ptr_addr));

  p_pair_installs_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ret_valid && ret_kind == 2'd2 && pend_w && !clr) |=> (valid_w != '0 && rec_valid));

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    clr |=> (valid_w == '0 && !pend_w));

  p_clear_beats_install_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    clr |=> !rec_valid);

  p_fill_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    !clr |=> $countones(valid_w) >= $past($countones(valid_w)));

  p_hit_needs_entry_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    lk_hit |-> valid_w != '0);

  p_orphan_indirect_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ret_valid && ret_kind == 2'd2 && !pend_w) |=> !rec_valid);
endmodule

bind stub_target_table stt_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n_i      (rst_n_i),
  .ret_valid    (ret_valid),
  .ret_kind     (ret_kind),
  .ret_ptr_addr (ret_ptr_addr),
  .clr          (clr),
  .pend_w       (pend_w),
  .lk_hit       (lk_hit),
  .rec_valid    (rec_valid),
  .rec_addr     (rec_addr),
  .valid_w      (valid_w)
);

// File: tb/test_stub_target_table.sv
module test_stub_target_table;
  localparam int D  = 4;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ret_valid;
  logic [1:0]    ret_kind;
  logic [AW-1:0] ret_target, ret_ptr_addr, lk_addr;
  logic          clr_filter, clr_ctx;
  logic          lk_hit, rec_valid;
  logic [AW-1:0] lk_target, rec_addr;

  always #10 clk = ~clk;

  stub_target_table #(.DEPTH(D), .AW(AW)) i_stub_target_table (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
    .ret_target(ret_target), .ret_ptr_addr(ret_ptr_addr),
    .clr_filter(clr_filter), .clr_ctx(clr_ctx), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_target(lk_target), .rec_valid(rec_valid), .rec_addr(rec_addr)
  );

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference
  logic [AW-1:0] m_key [D];
  logic [AW-1:0] m_val [D];
  bit            m_vld [D];
  int            m_ptr;
  bit            m_pend;
  logic [AW-1:0] m_pkey;
  bit            m_rec_v;
  logic [AW-1:0] m_rec_a;

  function automatic logic [AW-1:0] kk(input int i); return 48'h7f00_0000_0000 + AW'(i * 16); endfunction
  function automatic logic [AW-1:0] vv(input int i); return 48'h0000_5500_0000 + AW'(i * 256); endfunction
  function automatic logic [AW-1:0] pp(input int i); return 48'h6000_0000_0000 + AW'(i * 8); endfunction

  function automatic void m_reset();
    for (int i = 0; i < D; i++) m_vld[i] = 1'b0;
    m_ptr = 0; m_pend = 1'b0; m_rec_v = 1'b0;
  endfunction

  function automatic void m_install(input logic [AW-1:0] k, input logic [AW-1:0] v);
    int s = -1;
    for (int i = 0; i < D; i++) if (m_vld[i] && m_key[i] == k) s = i;
    if (s < 0) for (int i = D - 1; i >= 0; i--) if (!m_vld[i]) s = i;
    if (s < 0) begin s = m_ptr; m_ptr = (m_ptr + 1) % D; end
    m_key[s] = k; m_val[s] = v; m_vld[s] = 1'b1;
  endfunction

  function automatic void m_step();
    m_rec_v = 1'b0;
    if (clr_filter || clr_ctx) begin
      m_reset();
    end else if (ret_valid) begin
      if (ret_kind == 2'd1) begin
        m_pend = 1'b1; m_pkey = ret_target;
      end else begin
        if (ret_kind == 2'd2 && m_pend) begin
          m_install(m_pkey, ret_target);
          m_rec_v = 1'b1; m_rec_a = ret_ptr_addr;
        end
        m_pend = 1'b0;
      end
    end
  endfunction

  task automatic chk(input string tag, input logic [AW:0] act, input logic [AW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    bit h; logic [AW-1:0] v;
    #1;
    h = 1'b0; v = '0;
    for (int i = 0; i < D; i++) if (m_vld[i] && m_key[i] == lk_addr) begin h = 1'b1; v = m_val[i]; end
    chk("R10 lookup vs model", {lk_hit, lk_target}, {h, v});
    chk("R5 record vs model", {rec_valid, rec_valid ? rec_addr : {AW{1'b0}}},
        {m_rec_v, m_rec_v ? m_rec_a : {AW{1'b0}}});
    @(posedge clk);
    m_step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic ret(input logic [1:0] k, input logic [AW-1:0] t, input logic [AW-1:0] p);
    ret_valid = 1'b1; ret_kind = k; ret_target = t; ret_ptr_addr = p;
    cyc();
    ret_valid = 1'b0; ret_kind = 2'd0;
  endtask

  task automatic pair(input int kn, input int vn, input int pn);
    ret(2'd1, kk(kn), '0);
    ret(2'd2, vv(vn), pp(pn));
  endtask

  task automatic look(input string tag, input logic [AW-1:0] a, input bit eh, input logic [AW-1:0] et);
    lk_addr = a;
    #1;
    chk(tag, {lk_hit, lk_target}, {eh, et});
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ret_valid = 1'b0; ret_kind = 2'd0; ret_target = '0; ret_ptr_addr = '0;
    clr_filter = 1'b0; clr_ctx = 1'b0; lk_addr = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    look("R1 empty lookup at 0", '0, 1'b0, '0);
    look("R1 empty lookup at key", kk(1), 1'b0, '0);
    chk("R1 rec_valid low", {AW'(0), rec_valid}, '0);

    // R2 / R5: basic pair
    pair(1, 1, 1);
    look("R2 learned entry", kk(1), 1'b1, vv(1));
    chk("R5 record pulse", {rec_valid, rec_addr}, {1'b1, pp(1)});
    idle(1);
    chk("R5 record is one cycle", {AW'(0), rec_valid}, '0);

    // R4: bubbles between call and branch
    ret(2'd1, kk(2), '0);
    idle(2);
    ret(2'd2, vv(2), pp(2));
    look("R4 pair across bubbles", kk(2), 1'b1, vv(2));

    // R3: other kinds break the pair
    ret(2'd1, kk(3), '0);
    ret(2'd0, 48'h1234, '0);
    ret(2'd2, vv(3), pp(3));
    look("R3 kind 0 breaks pair", kk(3), 1'b0, '0);
    ret(2'd1, kk(3), '0);
    ret(2'd3, 48'h5678, '0);
    ret(2'd2, vv(3), pp(3));
    look("R3 kind 3 breaks pair", kk(3), 1'b0, '0);

    // R11: orphan indirect
    ret(2'd2, vv(9), pp(9));
    chk("R11 no record for orphan", {AW'(0), rec_valid}, '0);

    // R6 / R7: fill, overwrite, round-robin
    pair(1, 11, 4);
    look("R6 overwrite in place", kk(1), 1'b1, vv(11));
    look("R6 neighbour kept", kk(2), 1'b1, vv(2));
    pair(4, 4, 5);
    pair(5, 5, 6);
    pair(2, 12, 7);
    look("R6 full-table update keeps K1", kk(1), 1'b1, vv(11));
    look("R6 full-table update value", kk(2), 1'b1, vv(12));
    look("R6 full-table update keeps K5", kk(5), 1'b1, vv(5));
    pair(6, 6, 8);
    look("R7 first victim is slot 0", kk(1), 1'b0, '0);
    look("R7 new entry present", kk(6), 1'b1, vv(6));
    pair(7, 7, 9);
    look("R7 second victim is slot 1", kk(2), 1'b0, '0);
    look("R7 slot 2 survives", kk(4), 1'b1, vv(4));

    // R8: clears
    clr_filter = 1'b1; cyc(); clr_filter = 1'b0;
    look("R8 filter clear empties K4", kk(4), 1'b0, '0);
    look("R8 filter clear empties K7", kk(7), 1'b0, '0);
    ret(2'd1, kk(8), '0);
    clr_ctx = 1'b1; cyc(); clr_ctx = 1'b0;
    ret(2'd2, vv(8), pp(8));
    look("R8 pending call dropped", kk(8), 1'b0, '0);
    chk("R8 no record after drop", {AW'(0), rec_valid}, '0);

    // R9: clear against install
    ret(2'd1, kk(9), '0);
    clr_filter = 1'b1;
    ret(2'd2, vv(9), pp(9));
    clr_filter = 1'b0;
    look("R9 install dropped", kk(9), 1'b0, '0);
    chk("R9 no record", {AW'(0), rec_valid}, '0);

    // random interleaving, model compared every cycle (R2..R10)
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      ret_valid = (r >= 12);
      ret_kind = (r < 50) ? 2'd1 : (r < 82) ? 2'd2 : 2'(r % 4 == 0 ? 0 : 3);
      ret_target = (ret_kind == 2'd1) ? kk($urandom_range(0, 6)) : vv($urandom_range(0, 40));
      ret_ptr_addr = pp($urandom_range(0, 40));
      clr_filter = ($urandom_range(0, 99) < 2);
      clr_ctx = ($urandom_range(0, 99) < 2);
      lk_addr = kk($urandom_range(0, 7));
      cyc();
    end
    ret_valid = 1'b0; clr_filter = 1'b0; clr_ctx = 1'b0;
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule